// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out where a 32-bit RISC core fetches next and whether a control-transfer instruction writes a return address. Each cycle it takes the address of the current instruction, the instruction word and the values read from its two source registers. It returns the following fetch address, a link-write strobe, the destination register index for that write and the value to write.

The block handles these instruction forms:

- Branches that compare the two source registers for equality or inequality.
- Branches that test the sign of the first source register against zero.
- The linking forms of the sign branches.
- Jumps whose target sits inside the instruction word.
- Jumps that take their target from a register.

Branch offsets count instructions and are measured from the instruction that follows. Delay slots and exceptions are not modelled. All four results are registered once, so they describe the inputs presented at the previous rising clock edge.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `next_pc_o` equals the parameter `RESET_PC`. In the same cycles `link_we_o` is 0 and `link_idx_o` and `link_val_o` are 0.
- R2: An instruction that is not one of the forms below gives `next_pc_o` = PC+4 with no link write. Whenever no link write happens, `link_idx_o` and `link_val_o` read 0.
- R3: The two register-compare branches are selected by opcode bits [31:26]. Opcode 000100 is taken when rs equals rt, and opcode 000101 is taken when they differ.
  - Taken: the target is PC+4 plus the sign-extended bits [15:0] shifted left by two.
  - Not taken: the result is PC+4.
- R4: Two opcodes test rs alone, as a signed value, and ignore rt.
  - Opcode 000110 is taken when rs is zero or negative.
  - Opcode 000111 is taken when rs is strictly positive.
- R5: Opcode 000001 chooses its test from bits [20:16]. All four forms use the target rule of R3.
  - 00000: taken when rs is negative.
  - 00001: taken when rs is zero or positive.
  - 10000: linking version of 00000.
  - 10001: linking version of 00001.
  - Any other value: treated as a non-control instruction.
- R6: The linking sign branches write PC+4 to register `LINK_REG` only when taken. A linking branch that is not taken writes nothing.
- R7: Opcode 000010 jumps to {PC+4 bits [31:28], bits [25:0], 2'b00}. Opcode 000011 jumps to the same target and always writes PC+4 to register `LINK_REG`.
- R8: Opcode 000000 selects a register jump from bits [5:0].
  - Function 001000 sets `next_pc_o` = rs with no link write.
  - Function 001001 sets `next_pc_o` = rs and writes PC+4 to the register named by bits [15:11].
  - Other function codes are non-control.
- R9: The outputs change exactly one rising clock edge after the inputs they describe.
- R10: All address arithmetic wraps modulo 2^32, for negative offsets and for a PC near the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| next_pc_o | output | 32 | Address to fetch next |
| link_we_o | output | 1 | Return-address write strobe |
| link_idx_o | output | 5 | Register index for the return address |
| link_val_o | output | 32 | Return address (PC+4) |

## Verification
The bench sets `RESET_PC` to 32'hBFC0_0000 rather than zero. This way a reset value that only happens to be zero cannot pass. It keeps `LINK_REG` at 31, so a jump-and-link-register that names 31 cannot be told apart from a hard-wired index. Directed cases therefore also use a register jump that names register 5. Random cycles mix all opcodes, sign-boundary register values, equal operand pairs and PCs near the top of the address space, which reaches the wrap and sign-test edges.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int WORD_W  = 32;
    localparam int RIDX_W  = 5;
    localparam int OP_W    = 6;
    localparam int IMM_W   = 16;
    localparam int JIDX_W  = 26;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'b000000;
    localparam logic [OP_W-1:0] OP_SIGNSEL = 6'b000001;
    localparam logic [OP_W-1:0] OP_JMP     = 6'b000010;
    localparam logic [OP_W-1:0] OP_JMPLNK  = 6'b000011;
    localparam logic [OP_W-1:0] OP_BREQ    = 6'b000100;
    localparam logic [OP_W-1:0] OP_BRNE    = 6'b000101;
    localparam logic [OP_W-1:0] OP_BRLE0   = 6'b000110;
    localparam logic [OP_W-1:0] OP_BRGT0   = 6'b000111;

    localparam logic [OP_W-1:0] FN_REGJ    = 6'b001000;
    localparam logic [OP_W-1:0] FN_REGJLNK = 6'b001001;

    localparam logic [RIDX_W-1:0] SEL_LT0     = 5'b00000;
    localparam logic [RIDX_W-1:0] SEL_GE0     = 5'b00001;
    localparam logic [RIDX_W-1:0] SEL_LT0_LNK = 5'b10000;
    localparam logic [RIDX_W-1:0] SEL_GE0_LNK = 5'b10001;

    typedef enum logic [1:0] {
        XK_NONE,
        XK_BRANCH,
        XK_JUMP,
        XK_JREG
    } xfer_kind_e;

    typedef enum logic [2:0] {
        CND_NEVER,
        CND_EQ,
        CND_NE,
        CND_LEZ,
        CND_GTZ,
        CND_LTZ,
        CND_GEZ
    } cond_e;

    typedef struct packed {
        logic [WORD_W-1:0] next_pc;
        logic              link_we;
        logic [RIDX_W-1:0] link_idx;
        logic [WORD_W-1:0] link_val;
    } npc_state_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [RIDX_W-1:0] rt_field_i,
    input  logic [OP_W-1:0]   funct_i,
    output xfer_kind_e        kind_o,
    output cond_e             cond_o,
    output logic              link_req_o,
    output logic              link_to_rd_o
);

    always_comb begin
        kind_o       = XK_NONE;
        cond_o       = CND_NEVER;
        link_req_o   = 1'b0;
        link_to_rd_o = 1'b0;
        case (op_i)
            OP_BREQ: begin
                kind_o = XK_BRANCH;
                cond_o = CND_EQ;
            end
            OP_BRNE: begin
                kind_o = XK_BRANCH;
                cond_o = CND_NE;
            end
            OP_BRLE0: begin
                kind_o = XK_BRANCH;
                cond_o = CND_LEZ;
            end
            OP_BRGT0: begin
                kind_o = XK_BRANCH;
                cond_o = CND_GTZ;
            end
            OP_SIGNSEL: begin
                case (rt_field_i)
                    SEL_LT0: begin
                        kind_o = XK_BRANCH;
                        cond_o = CND_LTZ;
                    end
                    SEL_GE0: begin
                        kind_o = XK_BRANCH;
                        cond_o = CND_GEZ;
                    end
                    SEL_LT0_LNK: begin
                        kind_o     = XK_BRANCH;
                        cond_o     = CND_LTZ;
                        link_req_o = 1'b1;
                    end
                    SEL_GE0_LNK: begin
                        kind_o     = XK_BRANCH;
                        cond_o     = CND_GEZ;
                        link_req_o = 1'b1;
                    end
                    default: ;
                endcase
            end
            OP_JMP: begin
                kind_o = XK_JUMP;
            end
            OP_JMPLNK: begin
                kind_o     = XK_JUMP;
                link_req_o = 1'b1;
            end
            OP_SPECIAL: begin
                if (funct_i == FN_REGJ) begin
                    kind_o = XK_JREG;
                end else if (funct_i == FN_REGJLNK) begin
                    kind_o       = XK_JREG;
                    link_req_o   = 1'b1;
                    link_to_rd_o = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
(
    input  cond_e             cond_i,
    input  logic [WORD_W-1:0] rs_val_i,
    input  logic [WORD_W-1:0] rt_val_i,
    output logic              hit_o
);

    logic rs_neg;
    logic rs_zero;

    assign rs_neg  = rs_val_i[WORD_W-1];
    assign rs_zero = (rs_val_i == '0);

    always_comb begin
        case (cond_i)
            CND_EQ:  hit_o = (rs_val_i == rt_val_i);
            CND_NE:  hit_o = (rs_val_i != rt_val_i);
            CND_LEZ: hit_o = rs_neg | rs_zero;
            CND_GTZ: hit_o = ~rs_neg & ~rs_zero;
            CND_LTZ: hit_o = rs_neg;
            CND_GEZ: hit_o = ~rs_neg;
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
(
    input  logic [WORD_W-1:0] pc_i,
    input  logic [JIDX_W-1:0] jidx_i,
    output logic [WORD_W-1:0] pc_plus4_o,
    output logic [WORD_W-1:0] br_target_o,
    output logic [WORD_W-1:0] jmp_target_o
);

    localparam int EXT_W = WORD_W - IMM_W - 2;
    localparam int HI_W  = WORD_W - JIDX_W - 2;

    logic [IMM_W-1:0]  offset;
    logic [WORD_W-1:0] byte_offset;

    assign offset       = jidx_i[IMM_W-1:0];
    assign byte_offset  = {{EXT_W{offset[IMM_W-1]}}, offset, 2'b00};
    assign pc_plus4_o   = pc_i + WORD_W'(4);
    assign br_target_o  = pc_plus4_o + byte_offset;
    assign jmp_target_o = {pc_plus4_o[WORD_W-1 -: HI_W], jidx_i, 2'b00};

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter int          LINK_REG = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] pc_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] next_pc_o,
    output logic        link_we_o,
    output logic [4:0]  link_idx_o,
    output logic [31:0] link_val_o
);

    localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

    xfer_kind_e        kind;
    cond_e             cond;
    logic              link_req;
    logic              link_to_rd;
    logic              cond_hit;
    logic              taken;
    logic [WORD_W-1:0] pc_plus4;
    logic [WORD_W-1:0] br_target;
    logic [WORD_W-1:0] jmp_target;
    npc_state_t        state_d;
    npc_state_t        state_q;

    npc_decode i_decode (
        .op_i         (instr_i[31:26]),
        .rt_field_i   (instr_i[20:16]),
        .funct_i      (instr_i[5:0]),
        .kind_o       (kind),
        .cond_o       (cond),
        .link_req_o   (link_req),
        .link_to_rd_o (link_to_rd)
    );

    npc_cond_eval i_cond (
        .cond_i   (cond),
        .rs_val_i (rs_val_i),
        .rt_val_i (rt_val_i),
        .hit_o    (cond_hit)
    );

    npc_target_gen i_tgt (
        .pc_i         (pc_i),
        .jidx_i       (instr_i[JIDX_W-1:0]),
        .pc_plus4_o   (pc_plus4),
        .br_target_o  (br_target),
        .jmp_target_o (jmp_target)
    );

    always_comb begin
        state_d = '0;
        taken   = (kind == XK_BRANCH) ? cond_hit : (kind != XK_NONE);
        state_d.next_pc = pc_plus4;
        if (taken) begin
            case (kind)
                XK_BRANCH: state_d.next_pc = br_target;
                XK_JUMP:   state_d.next_pc = jmp_target;
                XK_JREG:   state_d.next_pc = rs_val_i;
                default:   state_d.next_pc = pc_plus4;
            endcase
        end
        if (taken && link_req) begin
            state_d.link_we  = 1'b1;
            state_d.link_idx = link_to_rd ? instr_i[15:11] : LINK_IDX;
            state_d.link_val = pc_plus4;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.next_pc  <= RESET_PC;
        end else begin
            state_q <= state_d;
        end
    end

    assign next_pc_o  = state_q.next_pc;
    assign link_we_o  = state_q.link_we;
    assign link_idx_o = state_q.link_idx;
    assign link_val_o = state_q.link_val;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter int          LINK_REG = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] pc_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    input  logic [31:0] next_pc_o,
    input  logic        link_we_o,
    input  logic [4:0]  link_idx_o,
    input  logic [31:0] link_val_o
);

    logic        armed_q;
    logic [31:0] pc_p;
    logic [31:0] ins_p;
    logic [31:0] rs_p;
    logic [31:0] rt_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            pc_p    <= '0;
            ins_p   <= '0;
            rs_p    <= '0;
            rt_p    <= '0;
        end else begin
            armed_q <= 1'b1;
            pc_p    <= pc_i;
            ins_p   <= instr_i;
            rs_p    <= rs_val_i;
            rt_p    <= rt_val_i;
        end
    end

    logic [5:0]  p_op;
    logic [4:0]  p_rt;
    logic [5:0]  p_fn;
    logic [31:0] p_pc4;
    logic        p_ctrl;
    logic        p_regimm_lnk;

    assign p_op  = ins_p[31:26];
    assign p_rt  = ins_p[20:16];
    assign p_fn  = ins_p[5:0];
    assign p_pc4 = pc_p + 32'd4;
    assign p_regimm_lnk = (p_op == 6'd1) && (p_rt == 5'd16 || p_rt == 5'd17);
    assign p_ctrl = (p_op >= 6'd2 && p_op <= 6'd7)
                 || (p_op == 6'd1 && (p_rt == 5'd0 || p_rt == 5'd1 || p_regimm_lnk))
                 || (p_op == 6'd0 && (p_fn == 6'd8 || p_fn == 6'd9));

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (next_pc_o == RESET_PC && !link_we_o)); // R1

    AST_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !p_ctrl) |-> (next_pc_o == p_pc4 && !link_we_o
                                  && link_idx_o == 5'd0 && link_val_o == 32'd0)); // R2

    AST_BEQ_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && p_op == 6'd4 && rs_p != rt_p) |-> (next_pc_o == p_pc4)); // R3

    AST_GTZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && p_op == 6'd7 && rs_p == 32'd0) |-> (next_pc_o == p_pc4)); // R4

    AST_SIGN_LINK_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && p_regimm_lnk && link_we_o) |-> (link_idx_o == 5'(LINK_REG))); // R5

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && link_we_o) |-> (link_val_o == p_pc4)); // R6

    AST_JUMP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (p_op == 6'd2 || p_op == 6'd3))
            |-> (next_pc_o == {p_pc4[31:28], ins_p[25:0], 2'b00})); // R7

    AST_JREG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && p_op == 6'd0 && p_fn == 6'd8) |-> (next_pc_o == rs_p && !link_we_o)); // R8

endmodule

bind npc_unit npc_unit_chk #(
    .RESET_PC (RESET_PC),
    .LINK_REG (LINK_REG)
) i_npc_unit_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_i       (pc_i),
    .instr_i    (instr_i),
    .rs_val_i   (rs_val_i),
    .rt_val_i   (rt_val_i),
    .next_pc_o  (next_pc_o),
    .link_we_o  (link_we_o),
    .link_idx_o (link_idx_o),
    .link_val_o (link_val_o)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;

    localparam logic [31:0] TB_RESET_PC = 32'hBFC0_0000;
    localparam int          TB_LINK     = 31;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pc_i, instr_i, rs_val_i, rt_val_i;
    logic [31:0] next_pc_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_val_o;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    npc_unit #(.RESET_PC(TB_RESET_PC), .LINK_REG(TB_LINK)) i_npc_unit (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .instr_i(instr_i),
        .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .next_pc_o(next_pc_o),
        .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_val_o(link_val_o)
    );

    // Behavioural reference: plain integer arithmetic on the fields.
    task automatic model(input logic [31:0] pc, input logic [31:0] ins,
                         input logic [31:0] rs, input logic [31:0] rt,
                         output logic [31:0] e_pc, output logic e_we,
                         output logic [4:0] e_idx, output logic [31:0] e_val);
        int unsigned op, rtf, fn, rdf;
        longint      off;
        logic [31:0] seq;
        bit          tk, lk, ctl;
        op  = ins >> 26;
        rtf = (ins >> 16) & 32'h1F;
        rdf = (ins >> 11) & 32'h1F;
        fn  = ins & 32'h3F;
        off = longint'($signed(ins[15:0])) * 4;
        seq = pc + 32'd4;
        tk = 0; lk = 0; ctl = 0;
        e_pc = seq; e_we = 0; e_idx = 0; e_val = 0;
        if (op == 4 || op == 5 || op == 6 || op == 7 || op == 1) begin
            ctl = 1;
            if (op == 4) tk = (rs == rt);
            else if (op == 5) tk = (rs != rt);
            else if (op == 6) tk = ($signed(rs) <= 0);
            else if (op == 7) tk = ($signed(rs) > 0);
            else begin
                if (rtf == 0 || rtf == 16) tk = ($signed(rs) < 0);
                else if (rtf == 1 || rtf == 17) tk = ($signed(rs) >= 0);
                else ctl = 0;
                lk = (rtf == 16 || rtf == 17);
            end
            if (ctl && tk) e_pc = 32'(longint'(seq) + off);
            if (ctl && tk && lk) begin e_we = 1; e_idx = 5'(TB_LINK); e_val = seq; end
        end else if (op == 2 || op == 3) begin
            e_pc = (seq & 32'hF000_0000) | ((ins & 32'h03FF_FFFF) << 2);
            if (op == 3) begin e_we = 1; e_idx = 5'(TB_LINK); e_val = seq; end
        end else if (op == 0 && (fn == 8 || fn == 9)) begin
            e_pc = rs;
            if (fn == 9) begin e_we = 1; e_idx = 5'(rdf); e_val = seq; end
        end
    endtask

    task automatic compare(input string tag, input logic [31:0] e_pc, input logic e_we,
                           input logic [4:0] e_idx, input logic [31:0] e_val);
        checks++;
        if (next_pc_o !== e_pc || link_we_o !== e_we || link_idx_o !== e_idx
            || link_val_o !== e_val) begin
            failures++;
            $display("FAIL %s: got pc=%h we=%b idx=%0d val=%h, expected pc=%h we=%b idx=%0d val=%h",
                     tag, next_pc_o, link_we_o, link_idx_o, link_val_o, e_pc, e_we, e_idx, e_val);
        end
    endtask

    // Apply at a falling edge, check one rising edge later at the next falling edge (R9).
    task automatic step(input string tag, input logic [31:0] pc, input logic [31:0] ins,
                        input logic [31:0] rs, input logic [31:0] rt);
        logic [31:0] e_pc, e_val;
        logic        e_we;
        logic [4:0]  e_idx;
        pc_i = pc; instr_i = ins; rs_val_i = rs; rt_val_i = rt;
        model(pc, ins, rs, rt, e_pc, e_we, e_idx, e_val);
        @(negedge clk);
        compare(tag, e_pc, e_we, e_idx, e_val);
    endtask

    function automatic logic [31:0] ityp(input int op, input int rs, input int rt, input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] rtyp(input int rs, input int rd, input int fn);
        return {6'd0, 5'(rs), 5'd0, 5'(rd), 5'd0, 6'(fn)};
    endfunction

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog R9: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        pc_i = 32'h0000_1000; instr_i = ityp(3, 0, 0, 4); rs_val_i = 0; rt_val_i = 0;
        repeat (3) @(negedge clk);
        compare("R1 in reset", TB_RESET_PC, 1'b0, 5'd0, 32'd0);

        @(negedge clk);
        rst_n = 1'b1;
        step("R3 beq taken fwd",      32'h0040_0000, ityp(4, 3, 4, 4),       32'd7, 32'd7);
        step("R3 beq not taken",      32'h0040_0010, ityp(4, 3, 4, 4),       32'd7, 32'd8);
        step("R3 bne taken",          32'h0040_0020, ityp(5, 3, 4, 16'hFFFE), 32'd1, 32'd2);
        step("R3 bne not taken",      32'h0040_0030, ityp(5, 3, 4, 9),       32'd5, 32'd5);
        step("R10 neg offset wrap",   32'h0000_0004, ityp(4, 1, 1, 16'h8000), 32'd0, 32'd0);
        step("R10 top-of-space pc4",  32'hFFFF_FFFC, ityp(8, 1, 2, 5),       32'd0, 32'd0);
        step("R4 blez zero taken",    32'h0040_0100, ityp(6, 2, 9, 3),       32'd0, 32'hDEAD);
        step("R4 blez pos not taken", 32'h0040_0100, ityp(6, 2, 9, 3),       32'd1, 32'd0);
        step("R4 bgtz zero no",       32'h0040_0100, ityp(7, 2, 0, 3),       32'd0, 32'd0);
        step("R4 bgtz neg no",        32'h0040_0100, ityp(7, 2, 0, 3),       32'h8000_0000, 32'd0);
        step("R4 bgtz pos taken",     32'h0040_0100, ityp(7, 2, 0, 3),       32'h7FFF_FFFF, 32'd0);
        step("R5 bltz taken",         32'h0040_0200, ityp(1, 2, 0, 8),       32'hFFFF_FFFF, 32'd0);
        step("R5 bgez zero taken",    32'h0040_0200, ityp(1, 2, 1, 8),       32'd0, 32'd0);
        step("R5 rt sel 00010 noop",  32'h0040_0200, ityp(1, 2, 2, 8),       32'd0, 32'd0);
        step("R6 bgezal taken link",  32'h0040_0300, ityp(1, 2, 17, 16'hFFF0), 32'd3, 32'd0);
        step("R6 bltzal not taken",   32'h0040_0300, ityp(1, 2, 16, 6),      32'd3, 32'd0);
        step("R6 bltzal taken link",  32'h0040_0300, ityp(1, 2, 16, 6),      32'h8000_0001, 32'd0);
        step("R7 j pseudo-direct",    32'h9000_0040, {6'd2, 26'd32},         32'd0, 32'd0);
        step("R7 jal links",          32'h3FFF_FFFC, {6'd3, 26'h3FF_FFFF},   32'd0, 32'd0);
        step("R8 jr",                 32'h0040_0400, rtyp(31, 0, 8),         32'h1234_5678, 32'd0);
        step("R8 jalr rd5",           32'h0040_0400, rtyp(3, 5, 9),          32'h0000_0800, 32'd0);
        step("R8 funct other noop",   32'h0040_0400, rtyp(3, 5, 10),         32'h0000_0800, 32'd0);
        step("R2 load word noop",     32'h0040_0500, ityp(35, 3, 2, 128),    32'd1, 32'd2);

        for (int n = 0; n < 600; n++) begin
            logic [31:0] ins, rs, rt, pc;
            int k;
            k  = int'($urandom % 12);
            pc = {$urandom} & 32'hFFFF_FFFC;
            if (n % 7 == 0) pc = 32'hFFFF_FFF0 + (($urandom % 4) * 4);
            rs = $urandom;
            case ($urandom % 4)
                0: rs = 32'd0;
                1: rs = 32'h8000_0000;
                2: rs = 32'h7FFF_FFFF;
                default: ;
            endcase
            rt = ($urandom % 2 == 0) ? rs : $urandom;
            ins = $urandom;
            case (k)
                0: ins[31:26] = 6'd4;
                1: ins[31:26] = 6'd5;
                2: ins[31:26] = 6'd6;
                3: ins[31:26] = 6'd7;
                4: begin ins[31:26] = 6'd1; ins[20:16] = 5'($urandom % 2); end
                5: begin ins[31:26] = 6'd1; ins[20:16] = 5'd16 + 5'($urandom % 2); end
                6: ins[31:26] = 6'd1;
                7: ins[31:26] = 6'd2;
                8: ins[31:26] = 6'd3;
                9: begin ins[31:26] = 6'd0; ins[5:0] = 6'd8 + 6'($urandom % 2); end
                10: ins[31:26] = 6'd0;
                default: ;
            endcase
            step("R9 random mix", pc, ins, rs, rt);
        end

        rst_n = 1'b0;
        #1;
        compare("R1 async reset", TB_RESET_PC, 1'b0, 5'd0, 32'd0);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

endmodule